// File: doc/BRIEF.md
# External Fast Interrupt Request Controller

This block takes one active-low fast-interrupt pin from outside the chip and turns it into an active-low fast-interrupt request line for the processor. The pin is asynchronous to the core clock. It passes through a chain of synchronizing flops, and a request is recognised when the synchronized level goes from high to low. Each recognised request sets a sticky pending flag. The flag stays set until software clears it. Holding the pin low or releasing it has no further effect.

A single control register on a plain write/read register bus exposes the pending flag and a mask flag. The processor output is driven low only while a request is pending and not masked. The output is registered, so it follows the flag and mask one clock later. The interrupt handler clears the request by writing 1 to the pending bit, and this releases the output. A request edge that lands in the same cycle as such a clear is kept, so no request is lost.

Top module: `fiq_ext_ctrl`

## Requirements
- R1: While reset is held and after it is released, `reg_rdata` reads all zeros and `fiq_n` is high.
- R2: After a high-to-low transition of `ext_fiq_n`, the pending flag (bit 0 of `reg_rdata`) reads 1 on the third rising clock edge after the pin change, counting the two synchronizer flops and the flag register.
- R3: When the pending flag is 1 and the mask flag is 0, `fiq_n` goes low on the next rising edge. Otherwise it is high one edge later.
- R4: While the mask flag (bit 1, 1 = masked) is 1, a pending request keeps `fiq_n` high, and the pending flag still reads 1.
- R5: A write with bit 0 of `reg_wdata` set clears the pending flag on that edge, and `fiq_n` returns high on the following edge.
- R6: A write with bit 0 of `reg_wdata` at 0 leaves the pending flag unchanged.
- R7: If a detected falling edge and a write-one-to-clear of bit 0 occur in the same cycle, the pending flag stays 1.
- R8: The mask flag takes bit 1 of `reg_wdata` on every write and reads back in bit 1. Clearing the mask while a request is pending drives `fiq_n` low one edge later.
- R9: A pin held low after a clear, or a low-to-high transition of the pin, does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_fiq_n | input | 1 | Asynchronous active-low external fast-interrupt pin |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | DATA_W | Write data: bit 0 clears the pending flag when 1, bit 1 is the mask |
| reg_rdata | output | DATA_W | Read data: bit 0 pending, bit 1 mask, other bits zero |
| fiq_n | output | 1 | Registered active-low fast-interrupt request to the processor |

## Verification
On every clock, the checker verifies that the output follows the registered pending-and-unmasked condition one edge later, and that a detected edge sets the flag. It also verifies that a clear without a competing edge empties the flag, that the flag holds when neither event occurs, and that writes load the mask. The bench scenarios cover the rest. These are the full pin-to-output latency through the synchronizer, the collision of a fresh edge with a clear, and the fact that a held-low or rising pin raises nothing. They also cover the mask-then-unmask sequence as seen on the ports.

// File: rtl/fiq_ext_pkg.sv
// Shared constants for the external fast-interrupt controller.
// Assumes a control register whose low two bits carry pending and mask.
package fiq_ext_pkg;
    localparam int FLAG_BIT = 0;   // pending flag, write 1 to clear
    localparam int MASK_BIT = 1;   // mask flag, 1 = masked
    localparam int CTRL_W   = 2;   // number of implemented control bits
endpackage

// File: rtl/fiq_pin_sync.sv
// Multi-flop synchronizer for the asynchronous active-low pin.
// Assumes the pin idles high; the chain resets to the idle level.
module fiq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/fiq_fall_detect.sv
// Flags a high-to-low step of an already synchronized level for one cycle.
// Assumes the level idles high after reset.
module fiq_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic prev_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    assign fall = prev_q & ~level;
endmodule

// File: rtl/fiq_ctrl_reg.sv
// Control register holding the sticky pending flag and the mask flag.
// Assumes a one-cycle write strobe; a set event wins over a clear.
module fiq_ctrl_reg (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_evt,
    input  logic                        wr,
    input  logic [fiq_ext_pkg::CTRL_W-1:0] wbits,
    output logic                        flag,
    output logic                        mask
);
    import fiq_ext_pkg::*;

    logic clr_evt;
    assign clr_evt = wr & wbits[FLAG_BIT];

    // Pending flag: set by an edge, cleared by a write of 1, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    // Mask flag: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask <= 1'b0;
        else if (wr) mask <= wbits[MASK_BIT];
    end
endmodule

// File: rtl/fiq_out_drive.sv
// Registered active-low request toward the processor.
// Assumes flag and mask come from registers in the same clock domain.
module fiq_out_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic mask,
    output logic req_n
);
    // Drive low only for a pending, unmasked request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_n <= 1'b1;
        else        req_n <= ~(flag & ~mask);
    end
endmodule

// File: rtl/fiq_ext_ctrl.sv
// External fast-interrupt controller: synchronizes the pin, detects its
// falling edge, latches a pending flag, applies the mask and drives the
// active-low processor request. Assumes DATA_W >= 3 and a single register.
module fiq_ext_ctrl #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_fiq_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fiq_n
);
    import fiq_ext_pkg::*;

    logic pin_sync;
    logic fall_evt;
    logic req_flag;
    logic mask_flag;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[DATA_W-1:CTRL_W];

    fiq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_fiq_n),
        .sync_out (pin_sync)
    );

    fiq_fall_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pin_sync),
        .fall  (fall_evt)
    );

    fiq_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (fall_evt),
        .wr      (reg_wr),
        .wbits   (reg_wdata[CTRL_W-1:0]),
        .flag    (req_flag),
        .mask    (mask_flag)
    );

    fiq_out_drive u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (req_flag),
        .mask  (mask_flag),
        .req_n (fiq_n)
    );

    // Assemble the read view of the control register.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[FLAG_BIT] = req_flag;
        reg_rdata[MASK_BIT] = mask_flag;
    end
endmodule

// File: rtl/fiq_ext_ctrl_chk.sv
// Cycle-by-cycle property checker for fiq_ext_ctrl, attached by bind.
module fiq_ext_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fiq_n,
    input logic              req_flag,
    input logic              mask_flag,
    input logic              fall_evt,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata
);
    AST_FIQ_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flag && !mask_flag) |=> !fiq_n);                        // R3
    AST_FIQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_flag && !mask_flag) |=> fiq_n);                        // R4
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> req_flag);                                      // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[0] && !fall_evt) |=> !req_flag);        // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_evt && !(reg_wr && reg_wdata[0])) |=> $stable(req_flag)); // R6
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (mask_flag == $past(reg_wdata[1])));              // R8
endmodule

bind fiq_ext_ctrl fiq_ext_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fiq_n     (fiq_n),
    .req_flag  (req_flag),
    .mask_flag (mask_flag),
    .fall_evt  (fall_evt),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata)
);

// File: tb/fiq_ext_ctrl_tb.sv
module fiq_ext_ctrl_tb;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_fiq_n = 1'b1;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              fiq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] rd;
        logic              fn;
        string             tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    fiq_ext_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_fiq_n (ext_fiq_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fiq_n     (fiq_n)
    );

    // Monitor: compares the outputs against queued expectations.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (reg_rdata !== e.rd || fiq_n !== e.fn) begin
                errors++;
                $display("FAIL %s: rdata=%h fiq_n=%b expected rdata=%h fiq_n=%b",
                         e.tag, reg_rdata, fiq_n, e.rd, e.fn);
            end
        end
    end

    task automatic expect_out(input logic [DATA_W-1:0] rd, input logic fn, input string tag);
        exp_t e;
        e.rd = rd; e.fn = fn; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [DATA_W-1:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic finish_run();
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_out('0, 1'b1, "R1 in reset");
        step(1);
        rst_n = 1'b1;
        step(1);
        expect_out('0, 1'b1, "R1 after reset");

        // R2 / R3: one request, full latency
        step(1);
        ext_fiq_n = 1'b0;
        step(2);
        expect_out('0, 1'b1, "R2 not yet set");
        step(1);
        expect_out(32'h1, 1'b1, "R2 flag set");
        step(1);
        expect_out(32'h1, 1'b0, "R3 fiq asserted");
        ext_fiq_n = 1'b1;
        step(3);

        // R6: write with bit 0 clear
        reg_write(32'h0);
        expect_out(32'h1, 1'b0, "R6 flag kept");

        // R5: write one to clear
        reg_write(32'h1);
        expect_out('0, 1'b0, "R5 flag cleared");
        step(1);
        expect_out('0, 1'b1, "R5 fiq released");

        // R9: held low after clear, then rising edge
        ext_fiq_n = 1'b0;
        step(3);
        expect_out(32'h1, 1'b1, "R9 setup flag");
        reg_write(32'hFFFF_FFFD);
        step(6);
        expect_out('0, 1'b1, "R9 held low no new request");
        ext_fiq_n = 1'b1;
        step(6);
        expect_out('0, 1'b1, "R9 rising edge ignored");

        // R4: masked request
        reg_write(32'h2);
        expect_out(32'h2, 1'b1, "R8 mask reads back");
        ext_fiq_n = 1'b0;
        step(3);
        step(2);
        expect_out(32'h3, 1'b1, "R4 masked pending");
        ext_fiq_n = 1'b1;

        // R8: unmask re-asserts one edge later
        reg_write(32'h0);
        expect_out(32'h1, 1'b1, "R8 unmask same edge");
        step(1);
        expect_out(32'h1, 1'b0, "R8 unmask asserts");
        reg_write(32'h2);
        expect_out(32'h3, 1'b0, "R4 mask set");
        step(1);
        expect_out(32'h3, 1'b1, "R4 mask negates output");
        reg_write(32'h3);
        expect_out(32'h2, 1'b1, "R5 clear keeps mask");
        reg_write(32'h0);
        expect_out('0, 1'b1, "R8 mask cleared");

        // R7: new edge collides with clear
        ext_fiq_n = 1'b0;
        step(3);
        expect_out(32'h1, 1'b1, "R7 first request");
        ext_fiq_n = 1'b1;
        step(3);
        ext_fiq_n = 1'b0;
        step(2);
        reg_write(32'h1);
        expect_out(32'h1, 1'b0, "R7 collision keeps flag");
        ext_fiq_n = 1'b1;
        step(2);
        expect_out(32'h1, 1'b0, "R7 still pending");
        reg_write(32'h1);
        expect_out('0, 1'b0, "R5 final clear");
        step(1);
        expect_out('0, 1'b1, "R5 final release");

        done = 1'b1;
        finish_run();
    end
endmodule